// File: doc/BRIEF.md
# Eighteen-bit write-queue and read-back buffer

This block sits between a fast bus (side A) and a slow target (side B). Words sent from A toward B go into a four-entry synchronous queue. The queue runs on one clock and has two separate active-low strobes: one to load a word, one to unload a word. Each unloaded word lands in a registered output that drives side B. An active-low flag tells the A side when every entry is taken. An active-low synchronous clear empties the queue and sets the B-side output to all ones.

Data going the other way, from B to A, passes through a transparent latch. While the pass enable is high, the latch follows B. When the enable falls, the latch keeps the value it had. This read-back path has no link to the queue.

Each side has its own active-low drive enable. Because the pins are bidirectional, each one is modelled as three signals: input data, output data and an output-enable.

Top module: `rwbuf18`

## Requirements
- R1: The queue stores up to four 18-bit words and returns them in the order they were loaded.
- R2: At a rising clock edge, `wr_en_n` low loads `a_in`. At a rising clock edge, `rd_en_n` low moves the oldest word into the output register, so `b_out` shows that word after the edge.
- R3: `full_n` is low exactly when four words are held and high otherwise. It follows the edge that changed the occupancy.
- R4: A load attempted while the queue is full is discarded. The held words and their order do not change.
- R5: An unload attempted while the queue is empty has no effect, and `b_out` keeps its last value.
- R6: When `rst_n` is low at a rising edge, the queue becomes empty, `b_out` becomes all ones (18'h3FFFF) and `full_n` is high. This wins over both strobes in the same cycle.
- R7: A load and an unload in the same cycle both take effect when the queue is neither empty nor full. When it is empty, only the load happens. When it is full, only the unload happens.
- R8: While `pass_en` is high, `a_out` follows `b_in` without a clock. After `pass_en` falls, `a_out` holds the value captured at the fall, whatever `b_in` does.
- R9: `b_oe` is high exactly when `b_drive_n` is low, and `a_oe` is high exactly when `a_drive_n` is low. Neither enable changes the data on `a_out` or `b_out`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Queue clock |
| rst_n | input | 1 | Synchronous clear, active low |
| wr_en_n | input | 1 | Load strobe, active low |
| rd_en_n | input | 1 | Unload strobe, active low |
| full_n | output | 1 | Low when all four entries are taken |
| pass_en | input | 1 | Read-back latch pass enable |
| a_drive_n | input | 1 | Drive enable for side A, active low |
| b_drive_n | input | 1 | Drive enable for side B, active low |
| a_in | input | 18 | Data from side A |
| a_out | output | 18 | Read-back latch value toward side A |
| a_oe | output | 1 | Side A driver enable |
| b_in | input | 18 | Data from side B |
| b_out | output | 18 | Queue output register toward side B |
| b_oe | output | 1 | Side B driver enable |

## Verification
Four properties are checked on every clock cycle:
- Occupancy never goes above four.
- A load into a full queue never moves the write pointer.
- An unload from an empty queue never changes the output register.
- A clear is always followed by an all-ones output and a released full flag.

Other behaviour can only be shown by the bench's scenarios, where a queue model is compared against `b_out` and `full_n`. These behaviours are:
- the order of the words,
- the data values that come out,
- the boundary rules when a load and an unload happen together,
- the read-back latch holding across the fall of `pass_en`.

// File: rtl/rwbuf_pkg.sv
package rwbuf_pkg;
  localparam int unsigned WORD_W = 18;
  localparam int unsigned DEPTH  = 4;
  localparam int unsigned PTR_W  = $clog2(DEPTH);
  localparam int unsigned OCC_W  = PTR_W + 1;

  typedef logic [WORD_W-1:0] word_t;
  typedef logic [PTR_W-1:0]  ptr_t;
  typedef logic [OCC_W-1:0]  occ_t;

  function automatic ptr_t ptr_step(input ptr_t p);
    return (p == ptr_t'(DEPTH - 1)) ? '0 : p + ptr_t'(1);
  endfunction

  function automatic occ_t occ_update(input occ_t c, input logic ld, input logic ul);
    case ({ld, ul})
      2'b10:   return c + occ_t'(1);
      2'b01:   return c - occ_t'(1);
      default: return c;
    endcase
  endfunction
endpackage

// File: rtl/rwbuf_queue.sv
module rwbuf_queue
  import rwbuf_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  logic  ld_req,
  input  logic  ul_req,
  input  word_t din,
  output word_t qout,
  output logic  is_full
);
  word_t mem [DEPTH];
  ptr_t  wptr, rptr;
  occ_t  occ;
  word_t q_r;

  wire at_empty = (occ == '0);
  wire at_full  = (occ == occ_t'(DEPTH));
  wire ld_go    = ld_req && !at_full;
  wire ul_go    = ul_req && !at_empty;

  for (genvar g = 0; g < DEPTH; g++) begin : g_slot
    always_ff @(posedge clk) begin
      if (rst_n && ld_go && wptr == ptr_t'(g)) mem[g] <= din;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wptr <= '0;
      rptr <= '0;
      occ  <= '0;
      q_r  <= '1;
    end else begin
      if (ld_go) wptr <= ptr_step(wptr);
      if (ul_go) begin
        rptr <= ptr_step(rptr);
        q_r  <= mem[rptr];
      end
      occ <= occ_update(occ, ld_go, ul_go);
    end
  end

  assign qout    = q_r;
  assign is_full = at_full;

  AST_OCC_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    occ <= occ_t'(DEPTH)); // R3
  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
    (at_full && ld_req && !ul_req) |=> ($stable(wptr) && is_full)); // R4
  AST_EMPTY_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (at_empty && ul_req) |=> $stable(qout)); // R5
  AST_CLEAR_STATE: assert property (@(posedge clk)
    !rst_n |=> (qout == '1 && !is_full)); // R6
endmodule

// File: rtl/rwbuf_latch.sv
module rwbuf_latch
  import rwbuf_pkg::*;
(
  input  logic  pass,
  input  word_t d,
  output word_t q
);
  word_t held;

  always_latch begin
    if (pass) held = d;
  end

  assign q = held;
endmodule

// File: rtl/rwbuf18.sv
module rwbuf18
  import rwbuf_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en_n,
  input  logic              rd_en_n,
  output logic              full_n,
  input  logic              pass_en,
  input  logic              a_drive_n,
  input  logic              b_drive_n,
  input  logic [WORD_W-1:0] a_in,
  output logic [WORD_W-1:0] a_out,
  output logic              a_oe,
  input  logic [WORD_W-1:0] b_in,
  output logic [WORD_W-1:0] b_out,
  output logic              b_oe
);
  logic q_full;

  rwbuf_queue u_queue (
    .clk     (clk),
    .rst_n   (rst_n),
    .ld_req  (!wr_en_n),
    .ul_req  (!rd_en_n),
    .din     (a_in),
    .qout    (b_out),
    .is_full (q_full)
  );

  rwbuf_latch u_latch (
    .pass (pass_en),
    .d    (b_in),
    .q    (a_out)
  );

  assign full_n = !q_full;
  assign a_oe   = !a_drive_n;
  assign b_oe   = !b_drive_n;
endmodule

// File: tb/rwbuf18_tb_top.sv
module rwbuf18_tb_top;
  localparam int CLK_P = 10;
  localparam logic [17:0] ONES = 18'h3FFFF;

  logic clk = 0, rst_n = 0, wr_en_n = 1, rd_en_n = 1, pass_en = 0;
  logic a_drive_n = 1, b_drive_n = 1, full_n, a_oe, b_oe;
  logic [17:0] a_in = 0, b_in = 0, a_out, b_out;

  int checks = 0, errors = 0;
  logic [17:0] model[$];
  logic [17:0] exp_out;
  logic [17:0] seed = 18'h1ACE5;

  always #(CLK_P/2) clk = ~clk;

  rwbuf18 dut_i (.*);

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] expv);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, expv);
    end
  endtask

  // Drive one cycle at the falling edge, apply the queue rules, then compare at the next falling edge.
  task automatic step(input bit ld, input bit ul, input logic [17:0] d, input string req);
    bit full_now, empty_now;
    wr_en_n = !ld; rd_en_n = !ul; a_in = d;
    full_now  = (model.size() == 4);
    empty_now = (model.size() == 0);
    @(posedge clk);
    if (ul && !empty_now) exp_out = model.pop_front();
    if (ld && !full_now) model.push_back(d);
    @(negedge clk);
    chk(b_out == exp_out, req, b_out, exp_out);
    chk(full_n == (model.size() != 4), "R3", full_n, model.size() != 4);
  endtask

  task automatic do_clear(input bit ld, input bit ul);
    rst_n = 0; wr_en_n = !ld; rd_en_n = !ul; a_in = 18'h00123;
    @(posedge clk); @(negedge clk);
    model.delete(); exp_out = ONES;
    rst_n = 1; wr_en_n = 1; rd_en_n = 1;
    chk(b_out == ONES, "R6", b_out, ONES);
    chk(full_n == 1'b1, "R6", full_n, 1);
  endtask

  initial begin
    #(CLK_P * 100000);
    errors++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    exp_out = ONES;
    @(negedge clk);
    do_clear(1, 1); // R6 clear wins over both strobes
    step(0, 1, 0, "R5");                           // underflow
    step(1, 1, 18'h11111, "R7");                   // empty: load only
    chk(model.size() == 1, "R7", model.size(), 1);
    for (int i = 0; i < 3; i++) step(1, 0, 18'h20000 + 18'(i), "R2");
    chk(full_n == 0, "R3", full_n, 0);
    step(1, 0, 18'h3BEEF, "R4");                   // overflow discarded
    step(1, 1, 18'h05555, "R7");                   // full: unload only
    chk(b_out == 18'h11111, "R1", b_out, 18'h11111);
    step(1, 1, 18'h0AAAA, "R7");                   // middle: both
    for (int i = 0; i < 5; i++) step(0, 1, 0, "R1");
    step(0, 1, 0, "R5");
    // sweep of strobe patterns with pseudo-random data
    for (int i = 0; i < 400; i++) begin
      seed = {seed[16:0], seed[17] ^ seed[10]};
      step(seed[0], seed[3], seed, "R1");
    end
    do_clear(0, 0);
    // output enables
    a_drive_n = 0; b_drive_n = 1; #1;
    chk(a_oe == 1 && b_oe == 0, "R9", {a_oe, b_oe}, 2'b10);
    a_drive_n = 1; b_drive_n = 0; #1;
    chk(a_oe == 0 && b_oe == 1 && b_out == ONES, "R9", {a_oe, b_oe}, 2'b01);
    // read-back latch
    pass_en = 1; b_in = 18'h12345; #1;
    chk(a_out == 18'h12345, "R8", a_out, 18'h12345);
    b_in = 18'h0F0F0; #1;
    chk(a_out == 18'h0F0F0, "R8", a_out, 18'h0F0F0);
    pass_en = 0; #1;
    b_in = 18'h00001; #1;
    chk(a_out == 18'h0F0F0, "R8", a_out, 18'h0F0F0);
    @(negedge clk); @(negedge clk);
    chk(a_out == 18'h0F0F0, "R8", a_out, 18'h0F0F0);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule